// File: doc/BRIEF.md
# Stall Lockout and Auto-Restart Timer

This block watches a sensorless three-phase commutation sequencer and decides when the motor has failed to spin up or has stalled. A digital ramp counter takes the place of an analog timing capacitor. It charges in large steps on a rate tick while the sequencer is still in its open-loop startup mode. If the count reaches the high threshold, the block enters lockout. In lockout the power stage is disabled, the lock indicator goes high and the ramp discharges in small steps. When the ramp falls to the low threshold, the block issues a one-cycle restart request so that the sequencer begins again in startup mode. The outputs are then re-enabled.

The state machine has three states. MONITOR is normal supervision and is entered on reset. LOCKED holds the outputs off. RESTART is a single cycle that emits the restart request. The transitions are:
- MONITOR→LOCKED when the ramp is at the high threshold and protection is enabled.
- LOCKED→RESTART when the ramp is at the low threshold.
- LOCKED→MONITOR when protection is disabled.
- RESTART→MONITOR unconditionally.

In closed-loop driving mode the ramp is cleared on entry to that mode and on every commutation event, so a rotor that stops producing commutations is also caught. A thermal-fault input removes output enable at once, whatever the state.

Top module: `lockout_timer`

## Requirements
- R1: After reset, `drive_en` is 1, `lock_flag` is 0, `restart_req` is 0 and the ramp count is zero.
- R2: In startup mode (`startup_mode`=1) each cycle with `rate_tick`=1 adds UP_STEP to the ramp, saturating at HI_CODE. `comm_evt` has no effect in startup mode. The cycle after the ramp equals HI_CODE, `lock_flag` becomes 1.
- R3: A 1→0 transition of `startup_mode` clears the ramp to zero. Lockout therefore needs a full HI_CODE/UP_STEP fresh ticks after that.
- R4: In driving mode (`startup_mode`=0) the ramp is cleared by each `comm_evt`=1 and charges by UP_STEP on each tick between events. If it reaches HI_CODE, lockout is entered as in R2.
- R5: While locked, `lock_flag` is 1 and `drive_en` is 0, and each tick subtracts DN_STEP from the ramp, stopping at LO_CODE.
- R6: The cycle after a locked ramp reaches LO_CODE, `restart_req` is 1 for exactly one cycle, with `lock_flag` 0 and `drive_en` 1. Supervision then resumes with the ramp at zero.
- R7: `thermal_fault`=1 forces `drive_en` to 0 in the same cycle, combinationally, in every state. It changes neither `lock_flag` nor the ramp.
- R8: With `lock_en`=0 the ramp is held at zero and lockout is never entered. If `lock_en` falls while locked, the next cycle leaves lockout with `lock_flag` 0 and no restart request.
- R9: `lock_flag` is 0 in every state other than lockout, including throughout driving mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startup_mode | input | 1 | 1 = sequencer in open-loop startup, 0 = closed-loop driving |
| comm_evt | input | 1 | One-cycle pulse per detected commutation |
| thermal_fault | input | 1 | Over-temperature indication; disables drive |
| rate_tick | input | 1 | Ramp step enable, one cycle per tick |
| lock_en | input | 1 | 1 = lock protection active, 0 = timer tied off |
| drive_en | output | 1 | Power stage enable |
| restart_req | output | 1 | One-cycle request to restart the sequencer in startup mode |
| lock_flag | output | 1 | High while in lockout |

## Verification
The bench builds the block with HI_CODE=40, LO_CODE=8, UP_STEP=10 and DN_STEP=1. With these values lockout arrives after four ticks and recovery takes thirty-two. This brings both threshold crossings, the one-tick-short boundaries and the full 10:1 detect/recover asymmetry within a few dozen cycles per scenario. The small values also let the bench check saturation at the high threshold and the floor at the low threshold, with the ramp state inferred only through the tick count to lockout.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_RESTART = 2'd2
    } lk_state_e;
endpackage

// File: rtl/lockout_ramp.sv
module lockout_ramp #(
    parameter int HI_CODE = 280,
    parameter int LO_CODE = 50,
    parameter int UP_STEP = 10,
    parameter int DN_STEP = 1,
    parameter int CNT_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             up_en,
    input  logic             dn_en,
    output logic [CNT_W-1:0] cnt,
    output logic             at_hi,
    output logic             at_lo
);
    localparam logic [CNT_W-1:0] HI_V   = CNT_W'(HI_CODE);
    localparam logic [CNT_W-1:0] LO_V   = CNT_W'(LO_CODE);
    localparam logic [CNT_W-1:0] UP_V   = CNT_W'(UP_STEP);
    localparam logic [CNT_W-1:0] DN_V   = CNT_W'(DN_STEP);
    localparam logic [CNT_W-1:0] UP_LIM = CNT_W'(HI_CODE - UP_STEP);
    localparam logic [CNT_W-1:0] DN_LIM = CNT_W'(LO_CODE + DN_STEP);

    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        cnt_nx = cnt;
        if (clr) begin
            cnt_nx = '0;
        end else if (up_en) begin
            cnt_nx = (cnt >= UP_LIM) ? HI_V : cnt + UP_V;
        end else if (dn_en) begin
            cnt_nx = (cnt >= DN_LIM) ? cnt - DN_V : LO_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end

    assign at_hi = (cnt >= HI_V);
    assign at_lo = (cnt <= LO_V);
endmodule

// File: rtl/lockout_fsm.sv
module lockout_fsm
    import lockout_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      startup_mode,
    input  logic      comm_evt,
    input  logic      thermal_fault,
    input  logic      rate_tick,
    input  logic      lock_en,
    input  logic      at_hi,
    input  logic      at_lo,
    output lk_state_e state,
    output logic      clr,
    output logic      up_en,
    output logic      dn_en,
    output logic      drive_en,
    output logic      restart_req,
    output logic      lock_flag
);
    lk_state_e state_nx;
    logic      mode_q;
    logic      drv_entry;

    assign drv_entry = mode_q && !startup_mode;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_MONITOR: if (lock_en && at_hi) state_nx = ST_LOCKED;
            ST_LOCKED: begin
                if (!lock_en)   state_nx = ST_MONITOR;
                else if (at_lo) state_nx = ST_RESTART;
            end
            ST_RESTART: state_nx = ST_MONITOR;
            default:    state_nx = ST_MONITOR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_MONITOR;
            mode_q <= 1'b0;
        end else begin
            state  <= state_nx;
            mode_q <= startup_mode;
        end
    end

    always_comb begin
        clr         = !lock_en || (state == ST_RESTART) ||
                      ((state == ST_MONITOR) && !startup_mode && (drv_entry || comm_evt));
        up_en       = (state == ST_MONITOR) && rate_tick;
        dn_en       = (state == ST_LOCKED) && rate_tick;
        lock_flag   = (state == ST_LOCKED);
        restart_req = (state == ST_RESTART);
        drive_en    = (state != ST_LOCKED) && !thermal_fault;
    end
endmodule

// File: rtl/lockout_timer.sv
module lockout_timer
    import lockout_pkg::*;
#(
    parameter int HI_CODE = 280,
    parameter int LO_CODE = 50,
    parameter int UP_STEP = 10,
    parameter int DN_STEP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic startup_mode,
    input  logic comm_evt,
    input  logic thermal_fault,
    input  logic rate_tick,
    input  logic lock_en,
    output logic drive_en,
    output logic restart_req,
    output logic lock_flag
);
    localparam int CNT_W = $clog2(HI_CODE + 1);

    lk_state_e        state;
    logic             clr, up_en, dn_en, at_hi, at_lo;
    logic [CNT_W-1:0] cnt;

    lockout_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .startup_mode (startup_mode),
        .comm_evt     (comm_evt),
        .thermal_fault(thermal_fault),
        .rate_tick    (rate_tick),
        .lock_en      (lock_en),
        .at_hi        (at_hi),
        .at_lo        (at_lo),
        .state        (state),
        .clr          (clr),
        .up_en        (up_en),
        .dn_en        (dn_en),
        .drive_en     (drive_en),
        .restart_req  (restart_req),
        .lock_flag    (lock_flag)
    );

    lockout_ramp #(
        .HI_CODE(HI_CODE),
        .LO_CODE(LO_CODE),
        .UP_STEP(UP_STEP),
        .DN_STEP(DN_STEP),
        .CNT_W  (CNT_W)
    ) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .up_en(up_en),
        .dn_en(dn_en),
        .cnt  (cnt),
        .at_hi(at_hi),
        .at_lo(at_lo)
    );
endmodule

// File: rtl/lockout_timer_chk.sv
module lockout_timer_chk #(
    parameter int HI_CODE = 280,
    parameter int LO_CODE = 50,
    parameter int CNT_W   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             thermal_fault,
    input logic             lock_en,
    input logic             drive_en,
    input logic             restart_req,
    input logic             lock_flag,
    input logic [CNT_W-1:0] cnt
);
    // R5
    locked_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |-> !drive_en);
    // R7
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault |-> !drive_en);
    // R6
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);
    // R6
    restart_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> $past(lock_flag) && (cnt <= CNT_W'(LO_CODE)));
    // R2
    lock_at_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(cnt) == CNT_W'(HI_CODE));
    // R2
    ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HI_CODE));
    // R8
    disabled_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> !lock_flag && !restart_req);
    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_flag, restart_req}));
endmodule

bind lockout_timer lockout_timer_chk #(
    .HI_CODE(HI_CODE),
    .LO_CODE(LO_CODE),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thermal_fault(thermal_fault),
    .lock_en      (lock_en),
    .drive_en     (drive_en),
    .restart_req  (restart_req),
    .lock_flag    (lock_flag),
    .cnt          (cnt)
);

// File: tb/lockout_timer_test.sv
module lockout_timer_test;
    localparam int HI = 40;
    localparam int LO = 8;
    localparam int UP = 10;
    localparam int DN = 1;
    localparam int LOCK_TICKS = HI / UP;          // 4
    localparam int REC_TICKS  = (HI - LO) / DN;   // 32

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic startup_mode = 1'b0, comm_evt = 1'b0, thermal_fault = 1'b0;
    logic rate_tick = 1'b0, lock_en = 1'b1;
    logic drive_en, restart_req, lock_flag;
    int   n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    lockout_timer #(.HI_CODE(HI), .LO_CODE(LO), .UP_STEP(UP), .DN_STEP(DN)) uut (
        .clk(clk), .rst_n(rst_n), .startup_mode(startup_mode), .comm_evt(comm_evt),
        .thermal_fault(thermal_fault), .rate_tick(rate_tick), .lock_en(lock_en),
        .drive_en(drive_en), .restart_req(restart_req), .lock_flag(lock_flag)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {drive_en,restart_req,lock_flag} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {drive_en, restart_req, lock_flag};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            rate_tick = 1'b1;
            step();
            rate_tick = 1'b0;
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; startup_mode = mode; comm_evt = 1'b0;
        thermal_fault = 1'b0; rate_tick = 1'b0; lock_en = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        check("R1 reset", outs(), 3'b100);
    endtask

    task automatic t_startup_lock();
        do_reset(1'b1);
        tick(LOCK_TICKS - 1);
        comm_evt = 1'b1; step(); comm_evt = 1'b0;  // ignored in startup
        check("R2 one tick short", outs(), 3'b100);
        tick(1);
        step();
        check("R2 lock after HI", outs(), 3'b001);
    endtask

    task automatic t_recovery();
        do_reset(1'b1);
        tick(LOCK_TICKS); step();
        tick(REC_TICKS - 1); step();
        check("R5 still locked one tick short", outs(), 3'b001);
        tick(1);
        check("R5 locked at LO edge", outs(), 3'b001);
        step();
        check("R6 restart pulse", outs(), 3'b110);
        step();
        check("R6 pulse single cycle", outs(), 3'b100);
        tick(LOCK_TICKS - 1); step();
        check("R6 ramp restarted from zero", outs(), 3'b100);
        tick(1); step();
        check("R6 relock after full charge", outs(), 3'b001);
    endtask

    task automatic t_drive_entry();
        do_reset(1'b1);
        tick(LOCK_TICKS - 1);
        startup_mode = 1'b0; step();
        startup_mode = 1'b1; step();
        tick(LOCK_TICKS - 1); step();
        check("R3 cleared on driving entry", outs(), 3'b100);
        tick(1); step();
        check("R3 lock after fresh charge", outs(), 3'b001);
    endtask

    task automatic t_drive_stall();
        do_reset(1'b0);
        tick(LOCK_TICKS - 1);
        comm_evt = 1'b1; step(); comm_evt = 1'b0;
        tick(LOCK_TICKS - 1); step();
        check("R4 commutation clears ramp", outs(), 3'b100);
        check("R9 low while driving", {2'b00, lock_flag}, 3'b000);
        tick(1); step();
        check("R4 stall locks", outs(), 3'b001);
    endtask

    task automatic t_thermal();
        do_reset(1'b1);
        thermal_fault = 1'b1; #1;
        check("R7 fault disables drive", outs(), 3'b000);
        tick(LOCK_TICKS); step();
        check("R7 timer unaffected, locks", outs(), 3'b001);
        thermal_fault = 1'b0; #1;
        check("R7 fault removal keeps lock", outs(), 3'b001);
    endtask

    task automatic t_disable();
        do_reset(1'b1);
        lock_en = 1'b0;
        tick(3 * LOCK_TICKS); step();
        check("R8 disabled never locks", outs(), 3'b100);
        lock_en = 1'b1;
        tick(LOCK_TICKS); step();
        check("R8 enabled locks", outs(), 3'b001);
        lock_en = 1'b0; step();
        check("R8 leave lock without restart", outs(), 3'b100);
        step();
        check("R8 no later restart", outs(), 3'b100);
    endtask

    initial begin
        #(4 * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_startup_lock();
        t_recovery();
        t_drive_entry();
        t_drive_stall();
        t_thermal();
        t_disable();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule